// File: doc/BRIEF.md
# Three-Multiply Complex Twiddle Multiplier

This block multiplies a complex sample by one of `NPTS` twiddle factors taken from an internal constant table, as the rotation step between butterfly stages of a pipelined FFT or IFFT. It takes one sample per clock. Each sample comes with a twiddle index and a direction bit. The rotated sample appears a fixed three cycles later.

The rotation uses three real multipliers where the textbook form uses four. For each twiddle `C + jS`, the table holds `C`, `C+S` and `C−S`. The two sums are one bit wider than `C` so that they never wrap. The datapath forms one shared term `Z = C·(X−Y)`. It then builds the real part as `(C−S)·Y + Z` and the imaginary part as `(C+S)·X − Z`. In the inverse direction the twiddle is conjugated. This is done without extra arithmetic: the two stored sums trade places. Both results are rounded and saturated back to the sample width.

Top module: `tw3_cmul`

## Requirements
- R1: A sample accepted with `in_valid` high at a rising clock edge produces `out_valid` high in the cycle after the third rising edge counted from that edge, including that edge. No other input event makes `out_valid` high.
- R2: With `in_inv` = 0, the twiddle for index k (an unsigned value on `in_idx`) is defined from A = 2^(CW−1), where round(v) = floor(v + 0.5) and clamping is to ±(2^(CW−1)−1):
  - C = clamp(round(A·cos(2πk/NPTS)))
  - S = clamp(round(−A·sin(2πk/NPTS)))
  - The outputs are the rounded values of X·C − Y·S (to `out_re`) and X·S + Y·C (to `out_im`), where X = `in_re` and Y = `in_im`, both two's complement.
- R3: With `in_inv` = 1, the output is the same as in R2 with S replaced by −S.
- R4: The rounding step computes each exact product sum P as (P + 2^(CW−2)) >> (CW−1), using an arithmetic shift. A fraction of exactly one half therefore rounds toward positive infinity.
- R5: The rounded result is saturated to the range −2^(DW−1) to 2^(DW−1)−1.
- R6: `out_re` and `out_im` keep their value in every cycle where `out_valid` is low. Data presented while `in_valid` is low is ignored.
- R7: While `rst` is high at a clock edge, `out_valid`, `out_re` and `out_im` are cleared to 0 after that edge, and every sample still in flight is discarded.
- R8: Samples on consecutive cycles produce results on consecutive cycles, one result per cycle.
- R9: A zero input sample gives a zero output for every index and either direction.
- R10: Index 0 gives an output within one LSB of the input sample in both parts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample is valid this cycle |
| in_re | input | DW | Real part X of the input sample, signed |
| in_im | input | DW | Imaginary part Y of the input sample, signed |
| in_idx | input | IDXW | Twiddle index k |
| in_inv | input | 1 | 1 selects the conjugate twiddle (inverse transform) |
| out_valid | output | 1 | Result is valid this cycle |
| out_re | output | DW | Real part of the rotated sample, signed |
| out_im | output | DW | Imaginary part of the rotated sample, signed |

## Verification
Every result is due exactly three rising edges after the edge that captured its sample. The bench stamps each expected item with the cycle count at which it must appear, and it samples on the falling edge. A result that arrives early, arrives late, or carries the wrong value is therefore reported against R1 or against its own value requirement.

In cycles without a result, the outputs are compared against the last result to check R6. A reset asserted while two samples are in flight must swallow both, and no stale result may surface after the reset.

// File: rtl/tw3_pkg.sv
package tw3_pkg;

   localparam real TW3_PI = 3.14159265358979323846;

   // nearest integer, halves upward
   function automatic longint tw3_round(real v);
      return longint'($rtoi($floor(v + 0.5)));
   endfunction

   // symmetric clamp to a signed width
   function automatic longint tw3_clamp(longint v, int w);
      longint lim;
      lim = (longint'(1) <<< (w - 1)) - 1;
      if (v > lim) return lim;
      if (v < -lim) return -lim;
      return v;
   endfunction

   function automatic longint tw3_cos_coef(int k, int n, int w);
      real amp;
      amp = real'(longint'(1) <<< (w - 1));
      return tw3_clamp(tw3_round(amp * $cos(2.0 * TW3_PI * real'(k) / real'(n))), w);
   endfunction

   function automatic longint tw3_sin_coef(int k, int n, int w);
      real amp;
      amp = real'(longint'(1) <<< (w - 1));
      return tw3_clamp(tw3_round(-amp * $sin(2.0 * TW3_PI * real'(k) / real'(n))), w);
   endfunction

endpackage

// File: rtl/tw3_rom.sv
module tw3_rom #(
   parameter int NPTS = 16,
   parameter int CW   = 16,
   parameter int IDXW = 4
) (
   input  logic [IDXW-1:0]       idx,
   output logic signed [CW-1:0]  coef_c,
   output logic signed [CW:0]    coef_sum,
   output logic signed [CW:0]    coef_dif
);
   localparam int KW = CW + 1;

   logic signed [CW-1:0] tab_c   [NPTS];
   logic signed [KW-1:0] tab_sum [NPTS];
   logic signed [KW-1:0] tab_dif [NPTS];

   for (genvar k = 0; k < NPTS; k++) begin : g_ent
      localparam longint CK = tw3_pkg::tw3_cos_coef(k, NPTS, CW);
      localparam longint SK = tw3_pkg::tw3_sin_coef(k, NPTS, CW);
      assign tab_c[k]   = CW'(CK);
      assign tab_sum[k] = KW'(CK + SK);
      assign tab_dif[k] = KW'(CK - SK);
   end

   assign coef_c   = tab_c[idx];
   assign coef_sum = tab_sum[idx];
   assign coef_dif = tab_dif[idx];
endmodule

// File: rtl/tw3_rndsat.sv
module tw3_rndsat #(
   parameter int IN_W     = 34,
   parameter int SHIFT    = 15,
   parameter int OUT_W    = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic signed [IN_W-1:0]  din,
   output logic signed [OUT_W-1:0] dout
);
   localparam int XW = IN_W + 1;
   localparam logic signed [XW-1:0] HALF = XW'(longint'(1) <<< (SHIFT - 1));
   localparam logic signed [XW-1:0] MAXV = XW'((longint'(1) <<< (OUT_W - 1)) - 1);
   localparam logic signed [XW-1:0] MINV = XW'(-(longint'(1) <<< (OUT_W - 1)));

   if (SHIFT < 1 || SHIFT >= IN_W) begin : g_bad_shift
      $error("tw3_rndsat: SHIFT out of range");
   end

   logic signed [XW-1:0] biased;
   logic signed [XW-1:0] scaled;

   assign biased = XW'(din) + HALF;
   assign scaled = biased >>> SHIFT;

   if (SATURATE) begin : g_sat
      always_comb begin
         if (scaled > MAXV)      dout = OUT_W'(MAXV);
         else if (scaled < MINV) dout = OUT_W'(MINV);
         else                    dout = OUT_W'(scaled);
      end
   end else begin : g_wrap
      assign dout = OUT_W'(scaled);
   end
endmodule

// File: rtl/tw3_cmul.sv
module tw3_cmul #(
   parameter int DW       = 16,
   parameter int CW       = 16,
   parameter int NPTS     = 16,
   parameter int IDXW     = $clog2(NPTS),
   parameter bit SATURATE = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  in_valid,
   input  logic signed [DW-1:0]  in_re,
   input  logic signed [DW-1:0]  in_im,
   input  logic [IDXW-1:0]       in_idx,
   input  logic                  in_inv,
   output logic                  out_valid,
   output logic signed [DW-1:0]  out_re,
   output logic signed [DW-1:0]  out_im
);
   localparam int KW   = CW + 1;        // width of C+S and C-S
   localparam int DXW  = DW + 1;        // width of X-Y
   localparam int PW   = DW + CW + 1;   // product width
   localparam int SW   = PW + 1;        // sum width
   localparam int FRAC = CW - 1;        // coefficient fraction bits

   if (DW < 4 || DW > 30) begin : g_bad_dw
      $error("tw3_cmul: DW must lie in 4..30");
   end
   if (CW < 4 || CW > 30) begin : g_bad_cw
      $error("tw3_cmul: CW must lie in 4..30");
   end
   if ((1 << IDXW) != NPTS) begin : g_bad_npts
      $error("tw3_cmul: NPTS must equal 2**IDXW");
   end

   // table lookup
   logic signed [CW-1:0] rom_c;
   logic signed [KW-1:0] rom_sum;
   logic signed [KW-1:0] rom_dif;

   tw3_rom #(.NPTS(NPTS), .CW(CW), .IDXW(IDXW)) u_rom (
      .idx      (in_idx),
      .coef_c   (rom_c),
      .coef_sum (rom_sum),
      .coef_dif (rom_dif)
   );

   // stage 1: operands and coefficients, conjugate by swapping sums
   logic                  s1_v;
   logic signed [DW-1:0]  s1_x, s1_y;
   logic signed [DXW-1:0] s1_d;
   logic signed [CW-1:0]  s1_c;
   logic signed [KW-1:0]  s1_kx, s1_ky;

   always_ff @(posedge clk) begin
      if (rst) s1_v <= 1'b0;
      else     s1_v <= in_valid;
   end

   always_ff @(posedge clk) begin
      if (in_valid) begin
         s1_x  <= in_re;
         s1_y  <= in_im;
         s1_d  <= DXW'(in_re) - DXW'(in_im);
         s1_c  <= rom_c;
         s1_kx <= in_inv ? rom_dif : rom_sum;
         s1_ky <= in_inv ? rom_sum : rom_dif;
      end
   end

   // stage 2: the three real products
   logic                 s2_v;
   logic signed [PW-1:0] s2_z, s2_pr, s2_pi;

   always_ff @(posedge clk) begin
      if (rst) s2_v <= 1'b0;
      else     s2_v <= s1_v;
   end

   always_ff @(posedge clk) begin
      if (s1_v) begin
         s2_z  <= PW'(s1_d)  * PW'(s1_c);
         s2_pr <= PW'(s1_ky) * PW'(s1_y);
         s2_pi <= PW'(s1_kx) * PW'(s1_x);
      end
   end

   // stage 3: one add, one subtract, round and saturate
   logic signed [SW-1:0] sum_re, sum_im;
   logic signed [DW-1:0] rnd_re, rnd_im;

   assign sum_re = SW'(s2_pr) + SW'(s2_z);
   assign sum_im = SW'(s2_pi) - SW'(s2_z);

   tw3_rndsat #(.IN_W(SW), .SHIFT(FRAC), .OUT_W(DW), .SATURATE(SATURATE)) u_rs_re (
      .din  (sum_re),
      .dout (rnd_re)
   );

   tw3_rndsat #(.IN_W(SW), .SHIFT(FRAC), .OUT_W(DW), .SATURATE(SATURATE)) u_rs_im (
      .din  (sum_im),
      .dout (rnd_im)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_re    <= '0;
         out_im    <= '0;
      end else begin
         out_valid <= s2_v;
         if (s2_v) begin
            out_re <= rnd_re;
            out_im <= rnd_im;
         end
      end
   end
endmodule

// File: rtl/tw3_cmul_chk.sv
module tw3_cmul_chk #(
   parameter int DW   = 16,
   parameter int IDXW = 4
) (
   input logic                 clk,
   input logic                 rst,
   input logic                 in_valid,
   input logic signed [DW-1:0] in_re,
   input logic signed [DW-1:0] in_im,
   input logic [IDXW-1:0]      in_idx,
   input logic                 out_valid,
   input logic signed [DW-1:0] out_re,
   input logic signed [DW-1:0] out_im
);
   logic [1:0] warm;
   always_ff @(posedge clk) begin
      if (rst)               warm <= 2'd0;
      else if (warm != 2'd3) warm <= warm + 2'd1;
   end

   // three-deep history of the inputs, held by the checker itself
   logic                 hv  [3];
   logic signed [DW-1:0] hre [3];
   logic signed [DW-1:0] him [3];
   logic [IDXW-1:0]      hix [3];

   always_ff @(posedge clk) begin
      hv[0]  <= in_valid;
      hre[0] <= in_re;
      him[0] <= in_im;
      hix[0] <= in_idx;
      for (int i = 1; i < 3; i++) begin
         hv[i]  <= hv[i-1];
         hre[i] <= hre[i-1];
         him[i] <= him[i-1];
         hix[i] <= hix[i-1];
      end
   end

   logic signed [DW:0] dre, dim;
   assign dre = DW'(out_re) - DW'(hre[2]) == '0 ? '0 : {out_re[DW-1], out_re} - {hre[2][DW-1], hre[2]};
   assign dim = {out_im[DW-1], out_im} - {him[2][DW-1], him[2]};

   AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
      (warm == 2'd3) |-> (out_valid == hv[2])) else $error("latency");                          // R1

   AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> (!out_valid && out_re == '0 && out_im == '0)) else $error("reset clear");           // R7

   AST_HOLD: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> ($stable(out_re) && $stable(out_im))) else $error("hold");                   // R6

   AST_ZERO_IN: assert property (@(posedge clk) disable iff (rst)
      (warm == 2'd3 && out_valid && hre[2] == '0 && him[2] == '0)
      |-> (out_re == '0 && out_im == '0)) else $error("zero in");                                 // R9

   AST_IDX0_NEAR: assert property (@(posedge clk) disable iff (rst)
      (warm == 2'd3 && out_valid && hix[2] == '0)
      |-> (dre >= -1 && dre <= 1 && dim >= -1 && dim <= 1)) else $error("index 0");               // R10
endmodule

bind tw3_cmul tw3_cmul_chk #(.DW(DW), .IDXW(IDXW)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .in_re     (in_re),
   .in_im     (in_im),
   .in_idx    (in_idx),
   .out_valid (out_valid),
   .out_re    (out_re),
   .out_im    (out_im)
);

// File: tb/sim_tw3_cmul.sv
module sim_tw3_cmul;
   localparam int DW   = 16;
   localparam int CW   = 16;
   localparam int NPTS = 16;
   localparam int IDXW = 4;
   localparam real PI  = 3.14159265358979323846;

   logic                 clk = 1'b0;
   logic                 rst = 1'b1;
   logic                 in_valid = 1'b0;
   logic signed [DW-1:0] in_re = '0;
   logic signed [DW-1:0] in_im = '0;
   logic [IDXW-1:0]      in_idx = '0;
   logic                 in_inv = 1'b0;
   logic                 out_valid;
   logic signed [DW-1:0] out_re, out_im;

   always #4 clk = ~clk;   // 125 MHz

   tw3_cmul #(.DW(DW), .CW(CW), .NPTS(NPTS)) u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
      .in_idx(in_idx), .in_inv(in_inv),
      .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
   );

   typedef struct {
      int    re;
      int    im;
      int    due;
      string tag;
   } exp_t;

   exp_t q[$];
   int   cyc = 0;
   int   n_chk = 0;
   int   n_bad = 0;
   bit   done = 1'b0;
   int   last_re = 0;
   int   last_im = 0;

   always @(posedge clk) cyc <= cyc + 1;

   // reference model from the requirements
   function automatic longint rnd(real v);
      return longint'($rtoi($floor(v + 0.5)));
   endfunction

   function automatic longint lim(longint v);
      longint m;
      m = (longint'(1) <<< (CW - 1)) - 1;
      return (v > m) ? m : (v < -m) ? -m : v;
   endfunction

   function automatic longint ref_c(int k);
      return lim(rnd(real'(longint'(1) <<< (CW - 1)) * $cos(2.0 * PI * real'(k) / real'(NPTS))));
   endfunction

   function automatic longint ref_s(int k);
      return lim(rnd(-real'(longint'(1) <<< (CW - 1)) * $sin(2.0 * PI * real'(k) / real'(NPTS))));
   endfunction

   function automatic int fin(longint p);
      longint t;
      t = (p + (longint'(1) <<< (CW - 2))) >>> (CW - 1);
      if (t > longint'(32767))  t = 32767;
      if (t < longint'(-32768)) t = -32768;
      return int'(t);
   endfunction

   task automatic chk(bit ok, string req, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   // driver: apply one sample and queue its expected result
   task automatic send(int x, int y, int k, bit inv, string tag);
      longint c = ref_c(k);
      longint s = ref_s(k);
      exp_t   e;
      if (inv) s = -s;
      @(negedge clk);
      in_valid = 1'b1;
      in_re    = DW'(x);
      in_im    = DW'(y);
      in_idx   = IDXW'(k);
      in_inv   = inv;
      e.re  = fin(longint'(x) * c - longint'(y) * s);
      e.im  = fin(longint'(x) * s + longint'(y) * c);
      e.due = cyc + 3;
      e.tag = tag;
      q.push_back(e);
   endtask

   // idle cycles with junk on the data inputs
   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
         in_re    = DW'($urandom);
         in_im    = DW'($urandom);
         in_idx   = IDXW'($urandom);
         in_inv   = 1'($urandom);
      end
   endtask

   // monitor: compare each result as it appears
   always @(negedge clk) begin
      exp_t e;
      if (rst) begin
         last_re = 0;
         last_im = 0;
      end else if (out_valid) begin
         if (q.size() == 0) begin
            chk(1'b0, "R1", "result without sample", 1, 0);
         end else begin
            e = q.pop_front();
            chk(cyc == e.due, "R1/R8", "arrival cycle", cyc, e.due);
            chk(int'(out_re) == e.re, e.tag, "real part", int'(out_re), e.re);
            chk(int'(out_im) == e.im, e.tag, "imag part", int'(out_im), e.im);
         end
         last_re = int'(out_re);
         last_im = int'(out_im);
      end else begin
         chk(int'(out_re) == last_re && int'(out_im) == last_im, "R6", "held real part",
             int'(out_re), last_re);
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R7 reset state
      chk(out_valid == 1'b0, "R7", "out_valid in reset", int'(out_valid), 0);
      chk(out_re == '0 && out_im == '0, "R7", "outputs in reset", int'(out_re), 0);
      rst = 1'b0;

      // R2, R8: forward sweep back to back
      for (int k = 0; k < NPTS; k++) send(12000, -7000, k, 1'b0, "R2");
      idle(4);
      // R3: inverse sweep
      for (int k = 0; k < NPTS; k++) send(-9100, 20500, k, 1'b1, "R3");
      idle(3);
      // R9: zero input
      for (int k = 0; k < NPTS; k += 3) send(0, 0, k, k[0], "R9");
      idle(2);
      // R10: index 0
      send(32767, -32768, 0, 1'b0, "R10");
      send(-1, 1, 0, 1'b1, "R10");
      send(5, -5, 0, 1'b0, "R10");
      // R4: exact halves, +16383.5 -> 16384 and -16383.5 -> -16383
      send(16384, -16384, 0, 1'b0, "R4");
      idle(2);
      // R5: saturation both ways at 45 degrees
      send(32767, 32767, 2, 1'b0, "R5");
      send(-32768, -32768, 2, 1'b0, "R5");
      send(32767, 32767, 2, 1'b1, "R5");
      send(-32768, 32767, 14, 1'b0, "R5");
      idle(6);   // R6 hold with junk inputs

      // R7: reset with two samples in flight
      send(1000, 2000, 3, 1'b0, "R7");
      send(3000, 4000, 5, 1'b0, "R7");
      @(negedge clk);
      in_valid = 1'b0;
      rst = 1'b1;
      q.delete();
      repeat (2) @(negedge clk);
      chk(out_valid == 1'b0, "R7", "out_valid after flush", int'(out_valid), 0);
      chk(out_re == '0 && out_im == '0, "R7", "outputs after flush", int'(out_re), 0);
      rst = 1'b0;
      idle(5);

      // R2 / R3: random samples with random gaps
      for (int n = 0; n < 300; n++) begin
         send(int'($signed(DW'($urandom))), int'($signed(DW'($urandom))),
              int'($urandom % NPTS), 1'($urandom), (n % 2 == 0) ? "R2" : "R3");
         if ($urandom % 4 == 0) idle(1 + int'($urandom % 3));
      end
      idle(1);
      while (q.size() != 0) @(negedge clk);
      idle(4);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d", q.size(), 0);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule